// File: doc/BRIEF.md
# Two-Antenna Space-Time Block Encoder

This block sits between a constellation mapper and the per-antenna OFDM modulators of a two-transmit-antenna radio. It accepts one stream of complex symbols, each carried as a signed two's-complement in-phase (I) and quadrature (Q) value, and spreads every consecutive pair of symbols over two output time slots on two antenna ports. The first slot sends the pair as it is. The second slot sends conjugated and negated copies with the symbols swapped between antennas. A receiver can then combine the two slots and recover both symbols with full transmit diversity.

Symbols are paired in the order they arrive. The source marks the last symbol of a data block with an end-of-block flag. When a block holds an odd number of symbols, the block closes its last pair with a null symbol (I = Q = 0), so every block leaves as a whole number of pairs. For example, a 52-bit block mapped at 4 bits per symbol gives 13 symbols, and these leave as 14 symbols, or 7 pairs. Both antenna ports share one valid strobe. Each pair occupies two consecutive valid output cycles.

Top module: `stbc_encoder`

## Requirements
- R1: In the first output slot of a pair, antenna 0 carries the earlier symbol s0 and antenna 1 carries the later symbol s1, both unchanged.
- R2: In the second output slot, antenna 0 carries the negated conjugate of s1, which is (neg(I1), neg(neg(Q1))). Antenna 1 carries the conjugate of s0, which is (I0, neg(Q0)).
- R3: No output slot is produced while only one symbol of a pair is held, however long the wait.
- R4: When no earlier pair is waiting or being sent, the first slot of a pair appears on the outputs after the third rising clock edge, counting the edge that accepts the pair's completing symbol as the first.
- R5: The two slots of a pair leave on consecutive clock cycles, with out_valid high in both.
- R6: A symbol accepted with in_eob set while no symbol is held is paired with a null symbol (0, 0) as s1.
- R7: A symbol accepted with in_eob set while a symbol is held completes that pair normally, and no null symbol is added.
- R8: neg(x) is the two's-complement negation, with the most negative code saturating to the most positive code. For 8-bit values, neg(0x80) = 0x7F, so neg(neg(0x80)) = 0x81.
- R9: The first symbol accepted after a padded block end starts a new pair. It waits for a partner and is not paired with anything earlier.
- R10: During reset, and in every cycle with out_valid low, out_valid and all four antenna outputs are zero.
- R11: Pairs are sent in order and none is lost when an odd-length block end is followed, after at least one idle input cycle, by further symbols. The source must leave that one idle cycle after every padded block end.
- R12: in_valid may drop for any number of cycles between the two symbols of a pair without changing the pair's content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| in_valid | input | 1 | Input symbol is valid this cycle |
| in_eob | input | 1 | Marks the symbol as the last of its block; ignored when in_valid is low |
| in_i | input | SYM_W | Input symbol I, signed |
| in_q | input | SYM_W | Input symbol Q, signed |
| out_valid | output | 1 | Both antenna outputs carry a slot this cycle |
| ant0_i | output | SYM_W | Antenna 0 I |
| ant0_q | output | SYM_W | Antenna 0 Q |
| ant1_i | output | SYM_W | Antenna 1 I |
| ant1_q | output | SYM_W | Antenna 1 Q |

## Verification
A pairing state that slips out of step with the input shows at once in the second slot, because it carries swapped, sign-altered copies of the wrong symbols. It also shows as pad slots with a zero antenna-1 symbol where none belongs, or as a lone symbol that never appears. A slot sequencer that loses its phase breaks the two-consecutive-cycle pattern within one pair. A queue fault reorders or drops pairs, and this shows on the next pair out. The saturation corners only show with the most negative and most positive codes.

// File: rtl/stbc_pkg.sv
package stbc_pkg;

  // Transform applied to one complex symbol
  typedef enum logic [1:0] {
    XF_PASS = 2'd0,
    XF_CONJ = 2'd1,
    XF_NEG  = 2'd2
  } xf_mode_e;

  // Pair collector: waiting for s0, or holding s0 and waiting for s1
  typedef enum logic {
    COL_EMPTY = 1'b0,
    COL_HELD  = 1'b1
  } col_state_e;

  // Slot sequencer: next cycle may start a pair, or must send slot 2
  typedef enum logic {
    SG_SLOT1 = 1'b0,
    SG_SLOT2 = 1'b1
  } sg_state_e;

endpackage

// File: rtl/stbc_cplx_op.sv
module stbc_cplx_op
  import stbc_pkg::*;
#(
  parameter int W = 8
) (
  input  xf_mode_e       mode,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   a_q,
  output logic [W-1:0]   y_i,
  output logic [W-1:0]   y_q
);

  localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_CODE = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  // Saturating two's-complement negation
  function automatic logic [W-1:0] sat_neg(input logic [W-1:0] x);
    if (x == MIN_CODE) return MAX_CODE;
    return ~x + ONE;
  endfunction

  always_comb begin
    case (mode)
      XF_CONJ: begin
        y_i = a_i;
        y_q = sat_neg(a_q);
      end
      XF_NEG: begin
        y_i = sat_neg(a_i);
        y_q = sat_neg(a_q);
      end
      default: begin
        y_i = a_i;
        y_q = a_q;
      end
    endcase
  end

endmodule

// File: rtl/stbc_pair_collect.sv
module stbc_pair_collect
  import stbc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_eob,
  input  logic [W-1:0]   in_i,
  input  logic [W-1:0]   in_q,
  output logic           pair_valid,
  output logic [4*W-1:0] pair_data   // {s0_i, s0_q, s1_i, s1_q}
);

  localparam int SW = 2 * W;

  col_state_e      state_q, state_n;
  logic [SW-1:0]   first_q;
  logic            first_en;
  logic            pv_q, pv_n;
  logic [4*W-1:0]  pd_q, pd_n;

  always_comb begin
    state_n  = state_q;
    first_en = 1'b0;
    pv_n     = 1'b0;
    pd_n     = pd_q;
    if (in_valid) begin
      case (state_q)
        COL_HELD: begin
          pv_n    = 1'b1;
          pd_n    = {first_q, in_i, in_q};
          state_n = COL_EMPTY;
        end
        default: begin
          if (in_eob) begin
            pv_n = 1'b1;
            pd_n = {in_i, in_q, {SW{1'b0}}};    // odd block end: null partner
          end else begin
            first_en = 1'b1;
            state_n  = COL_HELD;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= COL_EMPTY;
      pv_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      pv_q    <= pv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
    end else if (first_en) begin
      first_q <= {in_i, in_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= '0;
    end else if (pv_n) begin
      pd_q <= pd_n;
    end
  end

  assign pair_valid = pv_q;
  assign pair_data  = pd_q;

endmodule

// File: rtl/stbc_pair_fifo.sv
module stbc_pair_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [4*W-1:0] wr_data,
  input  logic           rd_en,
  output logic [4*W-1:0] rd_data,
  output logic           empty
);

  localparam int DW = 4 * W;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0]       wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [CW-1:0]       cnt_q, cnt_n;
  logic                full, wr_ok, rd_ok;
  logic [DEPTH*DW-1:0] ent_flat;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  always_comb begin
    wr_ptr_n = wr_ok ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_n = rd_ok ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    case ({wr_ok, rd_ok})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic          ent_en;
    logic [DW-1:0] ent_q;

    assign ent_en = wr_ok && (wr_ptr_q == PW'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= wr_data;
      end
    end

    assign ent_flat[e*DW +: DW] = ent_q;
  end

  always_comb begin
    rd_data = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (rd_ptr_q == PW'(e)) rd_data = ent_flat[e*DW +: DW];
    end
  end

endmodule

// File: rtl/stbc_slot_gen.sv
module stbc_slot_gen
  import stbc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fifo_empty,
  input  logic [4*W-1:0] fifo_data,   // {s0_i, s0_q, s1_i, s1_q}
  output logic           fifo_pop,
  output logic           out_valid,
  output logic [4*W-1:0] out_data     // {a0_i, a0_q, a1_i, a1_q}
);

  sg_state_e       state_q, state_n;
  logic [4*W-1:0]  hold_q;
  logic            v_q, v_n;
  logic [4*W-1:0]  o_q, o_n;

  logic [W-1:0] c1_i, c1_q, nc1_i, nc1_q, c0_i, c0_q;

  // Slot 2 antenna 0: conj(s1), then negate
  stbc_cplx_op #(.W(W)) u_conj_s1 (
    .mode (XF_CONJ),
    .a_i  (hold_q[2*W-1:W]),
    .a_q  (hold_q[W-1:0]),
    .y_i  (c1_i),
    .y_q  (c1_q)
  );

  stbc_cplx_op #(.W(W)) u_neg_s1 (
    .mode (XF_NEG),
    .a_i  (c1_i),
    .a_q  (c1_q),
    .y_i  (nc1_i),
    .y_q  (nc1_q)
  );

  // Slot 2 antenna 1: conj(s0)
  stbc_cplx_op #(.W(W)) u_conj_s0 (
    .mode (XF_CONJ),
    .a_i  (hold_q[4*W-1:3*W]),
    .a_q  (hold_q[3*W-1:2*W]),
    .y_i  (c0_i),
    .y_q  (c0_q)
  );

  always_comb begin
    state_n  = state_q;
    fifo_pop = 1'b0;
    v_n      = 1'b0;
    o_n      = '0;
    case (state_q)
      SG_SLOT2: begin
        v_n     = 1'b1;
        o_n     = {nc1_i, nc1_q, c0_i, c0_q};
        state_n = SG_SLOT1;
      end
      default: begin
        if (!fifo_empty) begin
          fifo_pop = 1'b1;
          v_n      = 1'b1;
          o_n      = fifo_data;   // slot 1: s0 on antenna 0, s1 on antenna 1
          state_n  = SG_SLOT2;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SG_SLOT1;
      v_q     <= 1'b0;
      o_q     <= '0;
    end else begin
      state_q <= state_n;
      v_q     <= v_n;
      o_q     <= o_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (fifo_pop) begin
      hold_q <= fifo_data;
    end
  end

  assign out_valid = v_q;
  assign out_data  = o_q;

endmodule

// File: rtl/stbc_encoder.sv
module stbc_encoder #(
  parameter int SYM_W      = 8,
  parameter int PAIR_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_eob,
  input  logic [SYM_W-1:0] in_i,
  input  logic [SYM_W-1:0] in_q,
  output logic             out_valid,
  output logic [SYM_W-1:0] ant0_i,
  output logic [SYM_W-1:0] ant0_q,
  output logic [SYM_W-1:0] ant1_i,
  output logic [SYM_W-1:0] ant1_q
);

  localparam int PDW = 4 * SYM_W;

  logic           pair_valid;
  logic [PDW-1:0] pair_data;
  logic           q_empty, q_pop;
  logic [PDW-1:0] q_data;
  logic [PDW-1:0] slot_data;

  stbc_pair_collect #(.W(SYM_W)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_eob     (in_eob),
    .in_i       (in_i),
    .in_q       (in_q),
    .pair_valid (pair_valid),
    .pair_data  (pair_data)
  );

  stbc_pair_fifo #(.W(SYM_W), .DEPTH(PAIR_DEPTH)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pair_valid),
    .wr_data (pair_data),
    .rd_en   (q_pop),
    .rd_data (q_data),
    .empty   (q_empty)
  );

  stbc_slot_gen #(.W(SYM_W)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (q_empty),
    .fifo_data  (q_data),
    .fifo_pop   (q_pop),
    .out_valid  (out_valid),
    .out_data   (slot_data)
  );

  assign ant0_i = slot_data[4*SYM_W-1:3*SYM_W];
  assign ant0_q = slot_data[3*SYM_W-1:2*SYM_W];
  assign ant1_i = slot_data[2*SYM_W-1:SYM_W];
  assign ant1_q = slot_data[SYM_W-1:0];

endmodule

// File: rtl/stbc_encoder_chk.sv
module stbc_encoder_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_eob,
  input logic         out_valid,
  input logic [W-1:0] ant0_i,
  input logic [W-1:0] ant0_q,
  input logic [W-1:0] ant1_i,
  input logic [W-1:0] ant1_q
);

  localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_CODE = {1'b0, {(W-1){1'b1}}};

  function automatic logic [W-1:0] neg_s(input logic [W-1:0] x);
    if (x == MIN_CODE) return MAX_CODE;
    return ~x + {{(W-1){1'b0}}, 1'b1};
  endfunction

  // Port-level tracking: input parity, output slot phase, pairs not yet started
  logic       odd_q;
  logic       phase_q;
  logic [2:0] pend_q;
  logic       pair_done, slot1_now, pend_idle;

  assign pair_done = in_valid && (odd_q || in_eob);
  assign slot1_now = out_valid && !phase_q;
  assign pend_idle = (pend_q == 3'd0) || ((pend_q == 3'd1) && slot1_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_q   <= 1'b0;
      phase_q <= 1'b0;
      pend_q  <= 3'd0;
    end else begin
      if (in_valid) odd_q <= !odd_q && !in_eob;
      if (out_valid) phase_q <= !phase_q;
      pend_q <= pend_q + {2'b00, pair_done} - {2'b00, slot1_now};
    end
  end

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (ant0_i == '0 && ant0_q == '0 && ant1_i == '0 && ant1_q == '0));

  p_slot_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |-> out_valid);

  p_slot2_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q && out_valid) |->
      (ant1_i == $past(ant0_i) && ant1_q == neg_s($past(ant0_q)) &&
       ant0_i == neg_s($past(ant1_i)) && ant0_q == neg_s(neg_s($past(ant1_q)))));

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_done && pend_idle) |=> ##2 out_valid);

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot1_now |-> (pend_q != 3'd0));

endmodule

bind stbc_encoder stbc_encoder_chk #(.W(SYM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_eob    (in_eob),
  .out_valid (out_valid),
  .ant0_i    (ant0_i),
  .ant0_q    (ant0_q),
  .ant1_i    (ant1_i),
  .ant1_q    (ant1_q)
);

// File: tb/sim_stbc_encoder.sv
module sim_stbc_encoder;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_eob;
  logic [W-1:0] in_i, in_q;
  logic         out_valid;
  logic [W-1:0] ant0_i, ant0_q, ant1_i, ant1_q;

  int n_chk = 0;
  int n_err = 0;
  int slots = 0;
  bit prev_slot1 = 1'b0;
  bit done = 1'b0;
  logic [32:0] exq [$];   // {slot2 flag, a0_i, a0_q, a1_i, a1_q}

  // {i0,q0,i1,q1} stimulus | {a0_i,a0_q,a1_i,a1_q} expected in slot 2
  localparam logic [63:0] VEC [6] = '{
    64'h03FB0702_F9020305,
    64'h80808080_7F81807F,   // most negative codes (R8)
    64'h7F7F7F7F_817F7F81,   // most positive codes (R8)
    64'h00000000_00000000,
    64'h010000FF_00FF0100,
    64'hFF40C064_4064FFC0
  };

  always #10 clk = ~clk;   // 50 MHz

  stbc_encoder #(.SYM_W(W), .PAIR_DEPTH(2)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_eob    (in_eob),
    .in_i      (in_i),
    .in_q      (in_q),
    .out_valid (out_valid),
    .ant0_i    (ant0_i),
    .ant0_q    (ant0_q),
    .ant1_i    (ant1_i),
    .ant1_q    (ant1_q)
  );

  function automatic logic [W-1:0] sneg(input logic [W-1:0] x);
    if (x == 8'h80) return 8'h7F;
    return 8'(-x);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_pair(input logic [W-1:0] i0, q0, i1, q1);
    exq.push_back({1'b0, i0, q0, i1, q1});
    exq.push_back({1'b1, sneg(i1), sneg(sneg(q1)), i0, sneg(q0)});
  endtask

  task automatic put(input logic [W-1:0] i, q, input logic e);
    @(negedge clk);
    in_valid = 1'b1;
    in_i     = i;
    in_q     = q;
    in_eob   = e;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_eob   = 1'b0;
      in_i     = '0;
      in_q     = '0;
    end
  endtask

  // Output monitor: every valid slot is compared with the next expected one
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (out_valid) begin
        logic [32:0] e;
        slots++;
        if (exq.size() == 0) begin
          chk(1'b0, "R3 slot with no completed pair", {ant0_i, ant0_q, ant1_i, ant1_q}, 32'h0);
          prev_slot1 = 1'b0;
        end else begin
          e = exq.pop_front();
          chk({ant0_i, ant0_q, ant1_i, ant1_q} == e[31:0],
              e[32] ? "R2 R8 slot2 mapping" : "R1 slot1 mapping",
              {ant0_i, ant0_q, ant1_i, ant1_q}, e[31:0]);
          prev_slot1 = !e[32];
        end
      end else begin
        if (prev_slot1) chk(1'b0, "R5 slot2 missing after slot1", 32'h0, 32'h1);
        chk({ant0_i, ant0_q, ant1_i, ant1_q} == 32'h0, "R10 idle outputs zero",
            {ant0_i, ant0_q, ant1_i, ant1_q}, 32'h0);
        prev_slot1 = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; in_valid = 1'b0; in_eob = 1'b0; in_i = '0; in_q = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0, "R10 out_valid in reset", {31'h0, out_valid}, 32'h0);
    chk({ant0_i, ant0_q, ant1_i, ant1_q} == 32'h0, "R10 outputs in reset",
        {ant0_i, ant0_q, ant1_i, ant1_q}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // Table walk: back-to-back pairs (R1, R2, R5, R8)
    base = slots;
    for (int v = 0; v < 6; v++) begin
      exq.push_back({1'b0, VEC[v][63:32]});
      exq.push_back({1'b1, VEC[v][31:0]});
      put(VEC[v][63:56], VEC[v][55:48], 1'b0);
      put(VEC[v][47:40], VEC[v][39:32], 1'b0);
    end
    idle(6);
    chk(slots == base + 12, "R5 slot count for table", 32'(slots - base), 32'd12);

    // R4: latency from the completing symbol
    push_pair(8'h11, 8'h22, 8'h33, 8'h44);
    put(8'h11, 8'h22, 1'b0);
    put(8'h33, 8'h44, 1'b0);
    @(negedge clk); in_valid = 1'b0;
    chk(out_valid == 1'b0, "R4 not after edge 1", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 not after edge 2", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R4 valid after edge 3", {31'h0, out_valid}, 32'h1);
    idle(4);

    // R3 and R12: lone symbol waits, gap inside a pair
    base = slots;
    push_pair(8'hA5, 8'h5A, 8'hC3, 8'h3C);
    put(8'hA5, 8'h5A, 1'b0);
    idle(8);
    chk(slots == base, "R3 lone symbol gives no slot", 32'(slots - base), 32'd0);
    put(8'hC3, 8'h3C, 1'b0);
    idle(6);
    chk(slots == base + 2, "R12 pair across gap", 32'(slots - base), 32'd2);

    // R6, R9, R7: odd block padded, new pair after it, even block end
    base = slots;
    push_pair(8'h01, 8'h02, 8'h03, 8'h04);
    push_pair(8'h85, 8'h86, 8'h00, 8'h00);
    put(8'h01, 8'h02, 1'b0);
    put(8'h03, 8'h04, 1'b0);
    put(8'h85, 8'h86, 1'b1);
    idle(1);
    push_pair(8'h10, 8'h20, 8'h30, 8'h40);
    put(8'h10, 8'h20, 1'b0);
    idle(6);
    chk(slots == base + 4, "R6 odd block padded", 32'(slots - base), 32'd4);
    chk(exq.size() == 2, "R9 symbol after pad waits", 32'(exq.size()), 32'd2);
    put(8'h30, 8'h40, 1'b1);
    idle(6);
    chk(slots == base + 6, "R7 even block end no pad", 32'(slots - base), 32'd6);

    // R11: padded end, one idle cycle, stream continues
    base = slots;
    push_pair(8'hF0, 8'h0F, 8'hE1, 8'h1E);
    push_pair(8'h7F, 8'h80, 8'h00, 8'h00);
    push_pair(8'h44, 8'h55, 8'h66, 8'h77);
    put(8'hF0, 8'h0F, 1'b0);
    put(8'hE1, 8'h1E, 1'b0);
    put(8'h7F, 8'h80, 1'b1);
    idle(1);
    put(8'h44, 8'h55, 1'b0);
    put(8'h66, 8'h77, 1'b0);
    idle(10);
    chk(slots == base + 6, "R11 all pairs delivered", 32'(slots - base), 32'd6);
    chk(exq.size() == 0, "R11 expected queue drained", 32'(exq.size()), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule